// File: doc/BRIEF.md
# Operand Addressing and Fetch Sequencer

This unit sits beside the decode stage of a 16-bit processor. The first word of the instruction has already been fetched. The unit receives:

- a three-bit addressing-mode code,
- the address of that first word,
- the value of the base register selected by the instruction,
- the carry flag.

From these it works out where the source operand lives. When the mode carries a constant, an address or a displacement, the unit reads it from the trailing word that follows the instruction. It forms the effective address and, when the operand sits in memory, fetches it through a word-addressed read port whose data returns one cycle after the request.

When the result is ready, a one-cycle `done` pulse qualifies five outputs: the operand, the effective address, the instruction length in words, the next program counter and an illegal-mode flag. The unit captures its inputs when `start` is accepted, so the caller may change them afterwards. A `start` that arrives while a resolution is under way is dropped.

The modes are immediate, direct, register indirect, base plus displacement, and a PC-relative jump. The jump is unconditional or gated by carry. PC-relative targets count from the word after the trailing word. All additions wrap modulo 2^16, and a displacement is used as a 16-bit two's-complement value.

Top module: `opfetch_top`

## Requirements
- R1: Mode code 0 (immediate). The operand is the word at instruction address A+1, `effAddr` is A+1, the length is 2 and `nextPc` is A+2. Exactly one memory read is made.
- R2: Mode code 1 (direct). The trailing word T at A+1 is an absolute address. The operand is the memory word at T, `effAddr` is T, the length is 2 and `nextPc` is A+2.
- R3: Mode code 2 (register indirect). The operand is the memory word at the base register value B, `effAddr` is B, the length is 1 and `nextPc` is A+1. No trailing word is read.
- R4: Mode code 3 (base plus displacement). `effAddr` is B plus the trailing word, modulo 2^16, and the operand is the memory word there. The length is 2 and `nextPc` is A+2. Example: B=0x1700 with displacement 0xA39D gives 0xBA9D.
- R5: Mode code 4 (jump). The target is A+2 plus the trailing word, modulo 2^16. `effAddr` and `nextPc` both equal the target, the operand is 0 and the length is 2. Example: A=0x017A with displacement 0x439D gives 0x4519.
- R6: Mode code 5 (jump if carry). `effAddr` is the target computed as in R5. `nextPc` is the target when the captured carry is 1 and A+2 when it is 0. The operand is 0 and the length is 2.
- R7: Mode codes 6 and 7 complete as a one-word no-operation. `illegal` is 1, the operand and `effAddr` are 0, the length is 1, `nextPc` is A+1, and no memory read is made. Every legal mode returns `illegal` as 0.
- R8: `done` lasts exactly one cycle, N cycles after the edge that accepts `start`: N=1 for codes 6 and 7, N=2 for codes 0, 2, 4 and 5, and N=3 for codes 1 and 3. `operand` changes only in a cycle where `done` is high.
- R9: A `start` pulse while a resolution is in progress has no effect on the outputs, the timing or the memory reads of that resolution.
- R10: After reset, `done` and `memRd` are 0 and the result outputs are 0.
- R11: A read is requested by `memRd` with `memAddr` in one cycle, and its data is taken from `memRdata` in the next cycle. The number of reads per resolution is 0 for codes 6 and 7, 1 for codes 0, 2, 4 and 5, and 2 for codes 1 and 3. `memRd` is never high while `done` is high.
- R12: `instrAddr`, `baseReg` and `carry` are captured at the accepting edge. Later changes to them do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a resolution; taken only when idle |
| mode | input | 3 | Addressing-mode code |
| instrAddr | input | 16 | Address of the instruction's first word |
| baseReg | input | 16 | Value of the selected base register |
| carry | input | 1 | Carry flag for the conditional jump |
| memAddr | output | 16 | Memory read address |
| memRd | output | 1 | Memory read request |
| memRdata | input | 16 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle result qualifier |
| operand | output | 16 | Resolved source operand |
| effAddr | output | 16 | Effective address or jump target |
| instrLen | output | 2 | Instruction length in words |
| nextPc | output | 16 | Address of the next instruction to run |
| illegal | output | 1 | Unused mode code was seen |

## Verification
Four properties hold on every cycle and are checked continuously:

- `done` is a single-cycle pulse.
- No read is requested while `done` is high.
- `operand` moves only under `done`.
- A completed result always reports a length of one or two, with an illegal result forced to one word and a zero operand.

The address arithmetic cannot be seen from any per-cycle property. The bench's scenarios must show it, driving:

- the carry-dependent choice of the next PC,
- wrap-around at 0xFFFF,
- the exact latency and read count of each mode,
- that a second `start` while busy, and later changes to the captured inputs, leave the result untouched.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  localparam logic [2:0] MD_IMM  = 3'd0;
  localparam logic [2:0] MD_DIR  = 3'd1;
  localparam logic [2:0] MD_RIND = 3'd2;
  localparam logic [2:0] MD_BASE = 3'd3;
  localparam logic [2:0] MD_JMP  = 3'd4;
  localparam logic [2:0] MD_JCS  = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRAIL = 2'd1,
    ST_OPER  = 2'd2,
    ST_DONE  = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    AS_TRAILER = 2'd0,
    AS_BASE    = 2'd1,
    AS_EA      = 2'd2
  } addrSel_t;

  typedef struct packed {
    logic     latch;
    logic     markIllegal;
    logic     takeTrailer;
    logic     takeOperand;
    logic     memRd;
    addrSel_t addrSel;
  } dpCtrl_t;

  function automatic logic modeLegal(input logic [2:0] m);
    return m <= MD_JCS;
  endfunction

  function automatic logic modeHasTrailer(input logic [2:0] m);
    return m != MD_RIND && modeLegal(m);
  endfunction

  function automatic logic modeReadsOperand(input logic [2:0] m);
    return m == MD_DIR || m == MD_BASE;
  endfunction

endpackage

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
  import opfetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] modeIn,
  input  logic [2:0] curMode,
  output dpCtrl_t    ctrl,
  output logic       done
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    ctrl         = '0;
    ctrl.addrSel = AS_TRAILER;
    done         = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.latch = 1'b1;
          if (!modeLegal(modeIn)) begin
            ctrl.markIllegal = 1'b1;
            stateNext        = ST_DONE;
          end else if (modeHasTrailer(modeIn)) begin
            ctrl.memRd   = 1'b1;
            ctrl.addrSel = AS_TRAILER;
            stateNext    = ST_TRAIL;
          end else begin
            ctrl.memRd   = 1'b1;
            ctrl.addrSel = AS_BASE;
            stateNext    = ST_OPER;
          end
        end
      end
      ST_TRAIL: begin
        ctrl.takeTrailer = 1'b1;
        if (modeReadsOperand(curMode)) begin
          ctrl.memRd   = 1'b1;
          ctrl.addrSel = AS_EA;
          stateNext    = ST_OPER;
        end else begin
          stateNext = ST_DONE;
        end
      end
      ST_OPER: begin
        ctrl.takeOperand = 1'b1;
        stateNext        = ST_DONE;
      end
      ST_DONE: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/opfetch_dp.sv
module opfetch_dp
  import opfetch_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      ctrl,
  input  logic [2:0]   modeIn,
  input  logic [W-1:0] instrIn,
  input  logic [W-1:0] baseIn,
  input  logic         carryIn,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] memAddr,
  output logic [2:0]   curMode,
  output logic [W-1:0] operand,
  output logic [W-1:0] effAddr,
  output logic [1:0]   instrLen,
  output logic [W-1:0] nextPc,
  output logic         illegal
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [2:0]   modeQ;
  logic [W-1:0] pcQ, baseQ;
  logic         carryQ;
  logic [W-1:0] eaFromTrailer, jumpTarget;

  assign curMode       = modeQ;
  assign eaFromTrailer = (modeQ == MD_DIR) ? memRdata : baseQ + memRdata;
  assign jumpTarget    = pcQ + TWO + memRdata;

  always_comb begin
    unique case (ctrl.addrSel)
      AS_BASE: memAddr = baseIn;
      AS_EA:   memAddr = eaFromTrailer;
      default: memAddr = instrIn + ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= '0;
      pcQ      <= '0;
      baseQ    <= '0;
      carryQ   <= 1'b0;
      operand  <= '0;
      effAddr  <= '0;
      instrLen <= 2'd0;
      nextPc   <= '0;
      illegal  <= 1'b0;
    end else begin
      if (ctrl.latch) begin
        modeQ   <= modeIn;
        pcQ     <= instrIn;
        baseQ   <= baseIn;
        carryQ  <= carryIn;
        illegal <= 1'b0;
      end
      if (ctrl.markIllegal) begin
        operand  <= '0;
        effAddr  <= '0;
        instrLen <= 2'd1;
        nextPc   <= instrIn + ONE;
        illegal  <= 1'b1;
      end
      if (ctrl.takeTrailer) begin
        instrLen <= 2'd2;
        unique case (modeQ)
          MD_IMM: begin
            operand <= memRdata;
            effAddr <= pcQ + ONE;
            nextPc  <= pcQ + TWO;
          end
          MD_JMP: begin
            operand <= '0;
            effAddr <= jumpTarget;
            nextPc  <= jumpTarget;
          end
          MD_JCS: begin
            operand <= '0;
            effAddr <= jumpTarget;
            nextPc  <= carryQ ? jumpTarget : pcQ + TWO;
          end
          default: begin
            effAddr <= eaFromTrailer;
            nextPc  <= pcQ + TWO;
          end
        endcase
      end
      if (ctrl.takeOperand) begin
        operand <= memRdata;
        if (modeQ == MD_RIND) begin
          effAddr  <= baseQ;
          instrLen <= 2'd1;
          nextPc   <= pcQ + ONE;
        end
      end
    end
  end

endmodule

// File: rtl/opfetch_top.sv
module opfetch_top
  import opfetch_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   mode,
  input  logic [W-1:0] instrAddr,
  input  logic [W-1:0] baseReg,
  input  logic         carry,
  output logic [W-1:0] memAddr,
  output logic         memRd,
  input  logic [W-1:0] memRdata,
  output logic         done,
  output logic [W-1:0] operand,
  output logic [W-1:0] effAddr,
  output logic [1:0]   instrLen,
  output logic [W-1:0] nextPc,
  output logic         illegal
);

  dpCtrl_t    ctrl;
  logic [2:0] curMode;

  assign memRd = ctrl.memRd;

  opfetch_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .modeIn  (mode),
    .curMode (curMode),
    .ctrl    (ctrl),
    .done    (done)
  );

  opfetch_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .modeIn   (mode),
    .instrIn  (instrAddr),
    .baseIn   (baseReg),
    .carryIn  (carry),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .curMode  (curMode),
    .operand  (operand),
    .effAddr  (effAddr),
    .instrLen (instrLen),
    .nextPc   (nextPc),
    .illegal  (illegal)
  );

endmodule

// File: rtl/opfetch_chk.sv
module opfetch_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         memRd,
  input logic         done,
  input logic [W-1:0] operand,
  input logic [1:0]   instrLen,
  input logic         illegal
);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_operand_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(operand));

  p_no_read_at_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRd);

  p_len_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (instrLen == 2'd1 || instrLen == 2'd2));

  p_illegal_nop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && illegal) |-> (operand == '0 && instrLen == 2'd1));

endmodule

bind opfetch_top opfetch_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memRd    (memRd),
  .done     (done),
  .operand  (operand),
  .instrLen (instrLen),
  .illegal  (illegal)
);

// File: tb/sim_opfetch_top.sv
`timescale 1ns/1ps
module sim_opfetch_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] instrAddr = '0;
  logic [15:0] baseReg = '0;
  logic        carry = 1'b0;
  logic [15:0] memAddr;
  logic        memRd;
  logic [15:0] memRdata = '0;
  logic        done;
  logic [15:0] operand, effAddr, nextPc;
  logic [1:0]  instrLen;
  logic        illegal;

  int total = 0;
  int bad = 0;
  int reads = 0;
  bit finished = 0;

  logic [15:0] mem [int unsigned];

  always #2.5 clk = ~clk;

  opfetch_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .instrAddr(instrAddr), .baseReg(baseReg), .carry(carry),
    .memAddr(memAddr), .memRd(memRd), .memRdata(memRdata),
    .done(done), .operand(operand), .effAddr(effAddr),
    .instrLen(instrLen), .nextPc(nextPc), .illegal(illegal)
  );

  function automatic logic [15:0] memVal(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a ^ 16'hC3A5;
  endfunction

  always @(posedge clk) begin
    if (memRd) begin
      memRdata <= memVal(memAddr);
      reads++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runInstr(input logic [2:0] m, input logic [15:0] a,
                          input logic [15:0] b, input logic c,
                          input bit poke, input string tag);
    int lat, expReads, rdBase;
    logic [15:0] tr, eOp, eEa, eNp;
    logic [1:0] eLen;
    logic eIll;
    tr = memVal(a + 16'd1);
    eIll = 1'b0;
    case (m)
      3'd0: begin eOp = tr; eEa = a + 16'd1; eLen = 2; eNp = a + 16'd2; lat = 2; expReads = 1; end
      3'd1: begin eEa = tr; eOp = memVal(eEa); eLen = 2; eNp = a + 16'd2; lat = 3; expReads = 2; end
      3'd2: begin eEa = b; eOp = memVal(b); eLen = 1; eNp = a + 16'd1; lat = 2; expReads = 1; end
      3'd3: begin eEa = b + tr; eOp = memVal(eEa); eLen = 2; eNp = a + 16'd2; lat = 3; expReads = 2; end
      3'd4: begin eEa = a + 16'd2 + tr; eOp = 0; eLen = 2; eNp = eEa; lat = 2; expReads = 1; end
      3'd5: begin eEa = a + 16'd2 + tr; eOp = 0; eLen = 2; eNp = c ? eEa : a + 16'd2; lat = 2; expReads = 1; end
      default: begin eEa = 0; eOp = 0; eLen = 1; eNp = a + 16'd1; eIll = 1; lat = 1; expReads = 0; end
    endcase
    @(negedge clk);
    rdBase = reads;
    start = 1'b1; mode = m; instrAddr = a; baseReg = b; carry = c;
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        // R12: scramble captured inputs after acceptance
        start = 1'b0; instrAddr = ~a; baseReg = ~b; carry = ~c; mode = 3'd1;
        if (poke) begin start = 1'b1; mode = 3'd2; end
      end
      if (n == 2) start = 1'b0;
      chk(done == (n == lat), "R8 done timing", 16'(done), 16'(n == lat));
      if (n == lat) begin
        chk(operand == eOp, {tag, " operand"}, operand, eOp);
        chk(effAddr == eEa, {tag, " effAddr"}, effAddr, eEa);
        chk(instrLen == eLen, {tag, " instrLen"}, 16'(instrLen), 16'(eLen));
        chk(nextPc == eNp, {tag, " nextPc"}, nextPc, eNp);
        chk(illegal == eIll, {tag, " R7 illegal"}, 16'(illegal), 16'(eIll));
      end
    end
    chk((reads - rdBase) == expReads, {tag, " R11 read count"},
        16'(reads - rdBase), 16'(expReads));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R10 done", 16'(done), 0);
    chk(memRd == 1'b0, "R10 memRd", 16'(memRd), 0);
    chk(operand == 0 && nextPc == 0 && effAddr == 0, "R10 outputs", operand, 0);
    rstN = 1'b1;

    mem[32'h017B] = 16'hA39D;
    mem[32'hA39D] = 16'hBC5F;
    mem[32'h875F] = 16'h10D5;
    mem[32'hBA9D] = 16'h5A17;
    runInstr(3'd0, 16'h017A, 16'h0000, 1'b0, 0, "R1 immediate");
    runInstr(3'd1, 16'h017A, 16'h0000, 1'b0, 0, "R2 direct");
    runInstr(3'd2, 16'h017A, 16'h875F, 1'b0, 0, "R3 reg indirect");
    runInstr(3'd3, 16'h017A, 16'h1700, 1'b0, 0, "R4 base");
    mem[32'h017B] = 16'h439D;
    runInstr(3'd4, 16'h017A, 16'h0000, 1'b0, 0, "R5 jump");
    runInstr(3'd5, 16'h017A, 16'h0000, 1'b1, 0, "R6 jump carry=1");
    runInstr(3'd5, 16'h017A, 16'h0000, 1'b0, 0, "R6 jump carry=0");
    runInstr(3'd6, 16'h2000, 16'h1111, 1'b0, 0, "R7 code6");
    runInstr(3'd7, 16'hFFFF, 16'h1111, 1'b1, 0, "R7 code7");
    // wrap-around cases
    mem[32'h0000] = 16'h0020;
    runInstr(3'd3, 16'hFFFF, 16'hFFF0, 1'b0, 0, "R4 base wrap");
    runInstr(3'd0, 16'hFFFF, 16'h0000, 1'b0, 0, "R1 immediate wrap");
    runInstr(3'd4, 16'hFFFF, 16'h0000, 1'b0, 0, "R5 jump wrap");
    mem[32'h3001] = 16'hFFF0;
    runInstr(3'd5, 16'h3000, 16'h0000, 1'b1, 0, "R6 backward");
    // start while busy
    mem[32'h4001] = 16'h5555;
    runInstr(3'd1, 16'h4000, 16'h875F, 1'b0, 1, "R9 busy start direct");
    runInstr(3'd0, 16'h4000, 16'h875F, 1'b0, 1, "R9 busy start imm");
    runInstr(3'd2, 16'h4000, 16'h875F, 1'b0, 1, "R9 busy start rind");
    runInstr(3'd1, 16'h5000, 16'h0000, 1'b0, 0, "R2 direct default mem");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule